// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Sequencer

This block turns host accesses on two register offsets into enhanced-parallel-port bus cycles. An access at offset 3 runs an address cycle. An access at offset 4 runs a data cycle. Each cycle is allowed only when the control bits, which the block receives as an input, match an exact pattern. The pattern for a write is different from the pattern for a read. A write that fails this check is dropped. A read that fails it returns all ones.

The data offset takes byte, half-word and word accesses. A wider access is broken into consecutive byte cycles on the port, least significant byte first, and read bytes are reassembled in the same order. Every byte cycle works as a handshake with the peripheral:

- For a write, the block first drives the direction line low.
- It then asserts the address strobe or the data strobe.
- It waits for the peripheral to raise its wait line, then releases the strobe.

If the peripheral does not answer within a set number of clocks, a sticky timeout flag is set and the rest of the access is abandoned. The flag is reported as status bit 0. The host clears it by writing a 1 to bit 0 of the status offset.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset the timeout flag is 0, busy is low, both strobes are high (inactive), the direction line is high and no read result is valid.
- R2: A write at offset 3 or 4 runs only when (control AND 0x2F) equals 0x04. Otherwise it is dropped: no strobe falls, busy stays low and the timeout flag is unchanged.
- R3: A read at offset 3 or 4 runs only when (control AND 0x2F) equals 0x24. Otherwise no strobe falls and the result is all ones at the access width (0xFF, 0xFFFF or 0xFFFFFFFF), valid one cycle after the access.
- R4: Offset 3 cycles use only the address strobe and offset 4 cycles use only the data strobe. The two strobes are never low together. The direction line is low only during write byte cycles.
- R5: The access size code selects the byte count: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Offset 3 always uses 1 byte. Write bytes go out least significant first, and read bytes fill the result from the least significant byte upward.
- R6: A byte cycle completes on the first clock edge at which the wait input is high while the strobe is low. The strobe is high again in the next cycle.
- R7: If the wait input stays low for TIMEOUT_CYC clock edges while a strobe is low, the timeout flag is set and the remaining bytes are skipped. On a read, the byte that timed out and every later byte read as 0xFF.
- R8: The timeout flag is sticky through later accesses. A write to offset 1 with data bit 0 equal to 1 clears it. A write there with bit 0 equal to 0 leaves it unchanged.
- R9: Busy is high from the cycle after an accepted access at offset 3 or 4 until the sequence ends. A read raises the read-valid output for exactly one cycle, while busy is still high. A write never raises read-valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access strobe, sampled when busy is low |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| acc_offset | input | 3 | Register offset: 1 status, 3 address, 4 data |
| acc_size | input | 2 | Access size: 0 byte, 1 half-word, 2 or 3 word |
| acc_wdata | input | 32 | Host write data |
| ctrl_bits | input | 8 | Current control register value |
| busy | output | 1 | A cycle sequence is in progress |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | 32 | Read result, byte 0 in bits 7:0 |
| tmo_flag | output | 1 | Sticky timeout flag (status bit 0) |
| port_write_n | output | 1 | Direction line, low for writes |
| port_astb_n | output | 1 | Address strobe, active low |
| port_dstb_n | output | 1 | Data strobe, active low |
| port_wait | input | 1 | Peripheral wait/acknowledge line |
| port_dout | output | 8 | Byte driven to the port |
| port_doe | output | 1 | Port data output enable |
| port_din | input | 8 | Byte sampled from the port |

## Verification
A flag clear or a dropped write takes effect at the clock edge that samples the access, so the bench checks it at the following falling edge. A gated read shows read-valid at that same falling edge. An accepted sequence lasts for a number of cycles that depends on the peripheral, so the bench polls on falling edges. It captures the result in the one cycle where read-valid is high, and it checks the flag, the port log and the strobe counts only once busy has fallen. The peripheral model registers its wait response one edge after it sees the strobe, so the answer delay is exact and a stall lasts past the timeout limit.

// File: rtl/epp_cyc_pkg.sv
package epp_cyc_pkg;

  localparam int HOST_W    = 32;
  localparam int LANE_W    = 8;
  localparam int LANES     = HOST_W / LANE_W;
  localparam int LANE_IDXW = $clog2(LANES);
  localparam int LANE_CNTW = LANE_IDXW + 1;

  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_ADDR   = 3'd3;
  localparam logic [2:0] OFS_DATA   = 3'd4;

  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR   = 8'h04;
  localparam logic [7:0] GATE_RD   = 8'h24;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_STROBE = 2'd2,
    SQ_FINISH = 2'd3
  } seq_state_t;

  // Number of byte lanes an access moves on the port.
  function automatic logic [LANE_CNTW-1:0] span_lanes(input logic is_addr,
                                                      input logic [1:0] size);
    if (is_addr) return LANE_CNTW'(1);
    case (size)
      2'd0:    return LANE_CNTW'(1);
      2'd1:    return LANE_CNTW'(2);
      default: return LANE_CNTW'(LANES);
    endcase
  endfunction

  // All-ones pattern covering the given number of lanes.
  function automatic logic [HOST_W-1:0] lane_ones(input logic [LANE_CNTW-1:0] n);
    logic [HOST_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(n)) m[i*LANE_W +: LANE_W] = '1;
    end
    return m;
  endfunction

  function automatic logic gate_pass(input logic [7:0] ctrl, input logic is_write);
    return (ctrl & GATE_MASK) == (is_write ? GATE_WR : GATE_RD);
  endfunction

endpackage

// File: rtl/epp_gate.sv
module epp_gate
  import epp_cyc_pkg::*;
(
  input  logic [7:0] ctrl,
  input  logic       is_write,
  output logic       pass
);
  always_comb pass = gate_pass(ctrl, is_write);
endmodule

// File: rtl/epp_strobe_timer.sv
module epp_strobe_timer #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  always_comb expired = run && (cnt_q == LAST);
endmodule

// File: rtl/epp_sticky_flag.sv
module epp_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_cyc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 reject_rd,
  input  logic                 is_write,
  input  logic                 is_addr,
  input  logic [LANE_CNTW-1:0] nlanes,
  input  logic [HOST_W-1:0]    wdata,
  input  logic                 wait_in,
  input  logic [LANE_W-1:0]    din,
  input  logic                 tmo_expired,
  output seq_state_t           state,
  output logic                 wr_q,
  output logic                 addr_q,
  output logic                 lane_done,
  output logic                 lane_tmo,
  output logic [HOST_W-1:0]    rbuf,
  output logic [LANE_W-1:0]    dout
);
  logic [LANE_CNTW-1:0] left_q;
  logic [LANE_IDXW-1:0] idx_q;
  logic [HOST_W-1:0]    wbuf_q;

  always_comb begin
    lane_done = (state == SQ_STROBE) && wait_in;
    lane_tmo  = (state == SQ_STROBE) && !wait_in && tmo_expired;
    dout      = wbuf_q[{idx_q, 3'b000} +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      wr_q   <= 1'b0;
      addr_q <= 1'b0;
      left_q <= '0;
      idx_q  <= '0;
      wbuf_q <= '0;
      rbuf   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (go) begin
            state  <= SQ_SETUP;
            wr_q   <= is_write;
            addr_q <= is_addr;
            left_q <= nlanes;
            idx_q  <= '0;
            wbuf_q <= wdata;
            rbuf   <= lane_ones(nlanes);
          end else if (reject_rd) begin
            state  <= SQ_FINISH;
            wr_q   <= 1'b0;
            addr_q <= is_addr;
            rbuf   <= lane_ones(nlanes);
          end
        end
        SQ_SETUP: state <= SQ_STROBE;
        SQ_STROBE: begin
          if (lane_done) begin
            if (!wr_q) rbuf[{idx_q, 3'b000} +: LANE_W] <= din;
            if (left_q == LANE_CNTW'(1)) state <= SQ_FINISH;
            else begin
              state  <= SQ_SETUP;
              left_q <= left_q - 1'b1;
              idx_q  <= idx_q + 1'b1;
            end
          end else if (lane_tmo) begin
            state <= SQ_FINISH;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_cyc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [2:0]  acc_offset,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  input  logic [7:0]  ctrl_bits,
  output logic        busy,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        tmo_flag,
  output logic        port_write_n,
  output logic        port_astb_n,
  output logic        port_dstb_n,
  input  logic        port_wait,
  output logic [7:0]  port_dout,
  output logic        port_doe,
  input  logic [7:0]  port_din
);
  // Named internal events
  logic                 accept;
  logic                 is_addr;
  logic                 is_cyc;
  logic                 gate_ok;
  logic                 cyc_go;
  logic                 rd_reject;
  logic                 flag_clr;
  logic [LANE_CNTW-1:0] nlanes;
  logic                 tmo_expired;
  logic                 lane_done;
  logic                 lane_tmo;
  logic                 wr_q;
  logic                 addr_q;
  logic                 strobing;
  seq_state_t           state;

  always_comb begin
    accept    = acc_valid && !busy;
    is_addr   = (acc_offset == OFS_ADDR);
    is_cyc    = is_addr || (acc_offset == OFS_DATA);
    cyc_go    = accept && is_cyc && gate_ok;
    rd_reject = accept && is_cyc && !gate_ok && !acc_write;
    flag_clr  = accept && acc_write && (acc_offset == OFS_STATUS) && acc_wdata[0];
    nlanes    = span_lanes(is_addr, acc_size);
  end

  epp_gate u_gate (
    .ctrl     (ctrl_bits),
    .is_write (acc_write),
    .pass     (gate_ok)
  );

  epp_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (cyc_go),
    .reject_rd   (rd_reject),
    .is_write    (acc_write),
    .is_addr     (is_addr),
    .nlanes      (nlanes),
    .wdata       (acc_wdata),
    .wait_in     (port_wait),
    .din         (port_din),
    .tmo_expired (tmo_expired),
    .state       (state),
    .wr_q        (wr_q),
    .addr_q      (addr_q),
    .lane_done   (lane_done),
    .lane_tmo    (lane_tmo),
    .rbuf        (rd_data),
    .dout        (port_dout)
  );

  epp_strobe_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (strobing),
    .expired (tmo_expired)
  );

  epp_sticky_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (lane_tmo),
    .clr   (flag_clr),
    .flag  (tmo_flag)
  );

  always_comb begin
    strobing     = (state == SQ_STROBE);
    busy         = (state != SQ_IDLE);
    rd_valid     = (state == SQ_FINISH) && !wr_q;
    port_write_n = !(wr_q && (state == SQ_SETUP || state == SQ_STROBE));
    port_doe     = !port_write_n;
    port_astb_n  = !(strobing && addr_q);
    port_dstb_n  = !(strobing && !addr_q);
  end
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [2:0]  acc_offset,
  input logic [31:0] acc_wdata,
  input logic [7:0]  ctrl_bits,
  input logic        busy,
  input logic        rd_valid,
  input logic        tmo_flag,
  input logic        port_write_n,
  input logic        port_astb_n,
  input logic        port_dstb_n,
  input logic        port_wait
);
  logic take, cyc_ofs, strobe_low, clear_req;
  always_comb begin
    take       = acc_valid && !busy;
    cyc_ofs    = (acc_offset == 3'd3) || (acc_offset == 3'd4);
    strobe_low = !port_astb_n || !port_dstb_n;
    clear_req  = take && acc_write && (acc_offset == 3'd1) && acc_wdata[0];
  end

  // R2: a write with the wrong control pattern never starts a sequence
  a_r2_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    take && acc_write && cyc_ofs && ((ctrl_bits & 8'h2F) != 8'h04) |=> !busy);

  // R3: a read with the wrong control pattern completes at once without a strobe
  a_r3_read_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    take && !acc_write && cyc_ofs && ((ctrl_bits & 8'h2F) != 8'h24) |=> rd_valid && !strobe_low);

  // R4: never both strobes at once
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!port_astb_n && !port_dstb_n));

  // R4: direction line low only inside a sequence
  a_r4_dir_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !port_write_n |-> busy);

  // R6: strobe released right after the peripheral answers
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low && port_wait |=> !strobe_low);

  // R7: the flag only rises from an unanswered strobe
  a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(strobe_low && !port_wait));

  // R8: the flag holds unless cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !clear_req |=> tmo_flag);

  // R9: read-valid only while busy
  a_r9_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_offset   (acc_offset),
  .acc_wdata    (acc_wdata),
  .ctrl_bits    (ctrl_bits),
  .busy         (busy),
  .rd_valid     (rd_valid),
  .tmo_flag     (tmo_flag),
  .port_write_n (port_write_n),
  .port_astb_n  (port_astb_n),
  .port_dstb_n  (port_dstb_n),
  .port_wait    (port_wait)
);

// File: tb/epp_cycle_ctrl_tb_top.sv
module epp_cycle_ctrl_tb_top;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_offset = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [7:0]  ctrl_bits = '0;
  logic        busy, rd_valid, tmo_flag;
  logic [31:0] rd_data;
  logic        port_write_n, port_astb_n, port_dstb_n, port_doe;
  logic [7:0]  port_dout, port_din;
  logic        port_wait;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  epp_cycle_ctrl #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .ctrl_bits(ctrl_bits), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .tmo_flag(tmo_flag), .port_write_n(port_write_n), .port_astb_n(port_astb_n),
    .port_dstb_n(port_dstb_n), .port_wait(port_wait), .port_dout(port_dout),
    .port_doe(port_doe), .port_din(port_din)
  );

  // Peripheral model
  logic        per_clr = 1'b0;
  int          stall_at = 8;
  int          resp_dly = 0;
  logic [31:0] rd_pat = '0;
  int          bidx, cur, pcnt, n_astb, n_dstb, n_logged;
  logic [7:0]  wlog [0:7];
  logic        prev_low;
  logic        slow;
  logic        stall_now;

  always_comb begin
    slow      = !port_astb_n || !port_dstb_n;
    stall_now = (slow && !prev_low) ? (bidx >= stall_at) : (cur >= stall_at);
  end
  assign port_din = rd_pat[(cur % 4) * 8 +: 8];

  always @(posedge clk) begin
    if (!rst_n || per_clr) begin
      bidx <= 0; cur <= 0; pcnt <= 0; n_astb <= 0; n_dstb <= 0; n_logged <= 0;
      prev_low <= 1'b0; port_wait <= 1'b0;
    end else begin
      prev_low <= slow;
      if (slow) begin
        if (!prev_low) begin
          cur  <= bidx;
          bidx <= bidx + 1;
          if (!port_astb_n) n_astb <= n_astb + 1;
          if (!port_dstb_n) n_dstb <= n_dstb + 1;
          if (!port_write_n && n_logged < 8) begin
            wlog[n_logged] <= port_dout;
            n_logged <= n_logged + 1;
          end
        end
        port_wait <= !stall_now && (pcnt >= resp_dly);
        pcnt <= pcnt + 1;
      end else begin
        port_wait <= 1'b0;
        pcnt <= 0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [2:0] ofs, input logic [1:0] sz);
    if (ofs == 3'd3) return 1;
    if (sz == 2'd0) return 1;
    if (sz == 2'd1) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] ones_of(input int n);
    logic [31:0] v = 32'h0;
    for (int i = 0; i < n; i++) v = (v << 8) | 32'hFF;
    return v;
  endfunction

  function automatic logic may_write(input logic [7:0] c);
    return !c[5] && !c[3] && c[2] && !c[1] && !c[0];
  endfunction

  function automatic logic may_read(input logic [7:0] c);
    return c[5] && !c[3] && c[2] && !c[1] && !c[0];
  endfunction

  logic [31:0] got_rd;
  int          got_valid;
  int          saw_busy;

  task automatic access(input logic wr, input logic [2:0] ofs, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [7:0] ctl, input int stall);
    @(negedge clk);
    per_clr  = 1'b1;
    stall_at = stall;
    resp_dly = int'($urandom % 5);
    rd_pat   = $urandom;
    @(negedge clk);
    per_clr   = 1'b0;
    acc_valid = 1'b1; acc_write = wr; acc_offset = ofs; acc_size = sz;
    acc_wdata = wd; ctrl_bits = ctl;
    @(negedge clk);
    acc_valid = 1'b0;
    got_valid = 0; saw_busy = 0; got_rd = 32'hDEAD_BEEF;
    for (int k = 0; k < 400; k++) begin
      if (rd_valid) begin got_rd = rd_data; got_valid++; end
      if (busy) saw_busy = 1;
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic status_write(input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_offset = 3'd1; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // Run one access and compare every observable result with the expected one
  task automatic run_and_check(input logic wr, input logic [2:0] ofs, input logic [1:0] sz,
                               input logic [31:0] wd, input logic [7:0] ctl, input int stall);
    int n, good;
    logic ok;
    logic flag_before;
    logic [31:0] exp;
    flag_before = tmo_flag;
    n  = lanes_of(ofs, sz);
    ok = wr ? may_write(ctl) : may_read(ctl);
    access(wr, ofs, sz, wd, ctl, stall);
    good = (stall < n) ? stall : n;
    check("R9 busy seen", 32'(saw_busy), 32'(ok || !wr));
    if (wr) begin
      check("R9 no rd_valid on write", 32'(got_valid), 32'd0);
      check("R2 bytes strobed", 32'(n_logged), ok ? 32'((stall < n) ? stall + 1 : n) : 32'd0);
      for (int i = 0; i < good && ok; i++)
        check("R5 write byte order", 32'(wlog[i]), 32'(wd[i*8 +: 8]));
    end else begin
      check("R9 single rd_valid", 32'(got_valid), 32'd1);
      exp = ones_of(n);
      if (ok) for (int i = 0; i < good; i++) exp[i*8 +: 8] = rd_pat[i*8 +: 8];
      check(ok ? "R5/R7 read assembly" : "R3 gated read ones", got_rd, exp);
      if (!ok) check("R3 no strobe", 32'(n_astb + n_dstb), 32'd0);
    end
    if (ok) begin
      check("R4 strobe kind", ofs == 3'd3 ? 32'(n_dstb) : 32'(n_astb), 32'd0);
      check("R7 flag", 32'(tmo_flag), 32'(flag_before || (stall < n)));
    end else begin
      check("R2 flag unchanged", 32'(tmo_flag), 32'(flag_before));
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flag", 32'(tmo_flag), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 strobes", {29'd0, port_astb_n, port_dstb_n, port_write_n}, 32'h7);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;

    // Directed cases
    run_and_check(1'b1, 3'd4, 2'd2, 32'hA1B2C3D4, 8'h04, 8); // R5 word write
    run_and_check(1'b0, 3'd4, 2'd1, 32'h0, 8'h24, 8);        // R5 half read
    run_and_check(1'b1, 3'd3, 2'd2, 32'h55, 8'hC4, 8);       // R4 address write, size ignored
    run_and_check(1'b1, 3'd4, 2'd0, 32'h11, 8'h24, 8);       // R2 dropped write
    run_and_check(1'b0, 3'd4, 2'd2, 32'h0, 8'h04, 8);        // R3 gated word read
    run_and_check(1'b0, 3'd3, 2'd0, 32'h0, 8'h2C, 8);        // R3 gated byte read
    run_and_check(1'b0, 3'd4, 2'd2, 32'h0, 8'h24, 2);        // R7 stall in third byte
    // R8 sticky: bit0 = 0 leaves it, bit0 = 1 clears
    status_write(32'hFE);
    check("R8 flag kept on bit0=0", 32'(tmo_flag), 32'd1);
    run_and_check(1'b1, 3'd4, 2'd0, 32'h77, 8'h04, 8);
    check("R8 flag sticky over access", 32'(tmo_flag), 32'd1);
    status_write(32'h01);
    check("R8 flag cleared", 32'(tmo_flag), 32'd0);
    run_and_check(1'b1, 3'd4, 2'd1, 32'hBEEF, 8'h04, 0);     // R7 write stall first byte
    status_write(32'h01);

    // Random mix
    for (int it = 0; it < 80; it++) begin
      logic [7:0] c;
      int sel;
      int st;
      sel = int'($urandom % 4);
      case (sel)
        0: c = 8'h04 | (8'($urandom) & 8'hD0);
        1: c = 8'h24 | (8'($urandom) & 8'hD0);
        2: c = 8'($urandom);
        default: c = ($urandom % 2 ? 8'h04 : 8'h24) ^ (8'h1 << ($urandom % 4));
      endcase
      st = ($urandom % 4 == 0) ? int'($urandom % 4) : 8;
      run_and_check(1'($urandom), ($urandom % 2) ? 3'd3 : 3'd4, 2'($urandom),
                    $urandom, c, st);
      if (tmo_flag) begin
        status_write(32'h01);
        check("R8 random clear", 32'(tmo_flag), 32'd0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule